// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scanner

This block drives a six-position seven-segment display whose commons are chosen through an external 3-to-8 decoder. Five positions show numeric digits taken from a packed BCD word. The sixth position shows a unit marker, a single segment that tells the reader whether the reading is in Hz, kHz or MHz. A position code places the decimal point on one of the digit positions.

The scanner moves through the positions at a fixed slot rate, one position per slot. Each slot opens with a short transition. First every common is released and the segments are turned off. Then the pattern for the next position is driven while all commons are still released. Only after that is the position's common selected. The value, decimal-point code and unit code are copied into shadow registers at the start of every slot, so a slot never mixes old and new data.

With the default parameters and a 50 MHz clock, a slot lasts 2 ms, which gives a 500 Hz slot rate.

Top module: `sevenseg_scanner`

## Requirements
- R1: Positions are selected in the order 0,1,2,3,4,5 and then wrap to 0. While a position is shown, `comSel` carries that position's index. While no position is shown, `comSel` carries the idle code 7, which matches no position.
- R2: Every slot lasts SLOT_CYCLES clock cycles. Within a slot, the position stays selected for exactly SLOT_CYCLES-1-BLANK_CYCLES consecutive cycles.
- R3: Position p, for p from 0 to NUM_DIGITS-1, shows the nibble at bits [(NUM_DIGITS-1-p)*4 +: 4] of `bcdValue`. Position 0 is therefore the most significant digit and position 4 the least significant.
- R4: Segment bits are a=bit0, b=bit1, c=bit2, d=bit3, e=bit4, f=bit5, g=bit6, decimal point=bit7. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Nibble values 10 to 15 give a blank pattern, 00.
- R5: Bit 7 is set at digit position p only when `dpCode` equals NUM_DIGITS-1-p. A code of NUM_DIGITS or above lights no decimal point. The unit position never shows a decimal point.
- R6: Position NUM_DIGITS shows the unit marker: code 0 gives 01 (segment a only), code 1 gives 40 (segment g only), code 2 gives 08 (segment d only), code 3 gives 00.
- R7: Each slot opens with one cycle in which `segOut` is 00 and `comSel` is idle. Then follow BLANK_CYCLES cycles in which `segOut` already shows the new position's pattern and `comSel` is still idle. `segOut` never changes while a position is selected.
- R8: `bcdValue`, `dpCode` and `unitCode` are sampled only at the start of a slot. Changing them in the middle of a slot does not affect that slot, and the next slot shows the new values.
- R9: A synchronous active-high `rst` drives `segOut` to 00 and `comSel` to idle. The first position selected after reset is 0, and it follows BLANK_CYCLES+1 idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcdValue | input | 4*NUM_DIGITS | Packed BCD value; position 0 is the top nibble |
| dpCode | input | DP_W | Decimal-point position code |
| unitCode | input | 2 | Unit marker code: 0 Hz, 1 kHz, 2 MHz |
| segOut | output | 8 | Segment pattern, a=bit0 through g=bit6, decimal point=bit7 |
| comSel | output | $clog2(NUM_DIGITS+2) | Common index for the external decoder; all ones is idle |

## Verification
The bench builds the scanner with NUM_DIGITS=5, SLOT_CYCLES=16 and BLANK_CYCLES=3. The short slot makes a full six-position rotation take under a hundred cycles, so many values, decimal-point codes and unit codes fit in one run. A blank window of three cycles keeps the single all-off cycle, the data-before-select cycles and the selected window apart, so the bench can count each phase on its own. The same short slot lets the bench change inputs in the middle of a selected window and see the old data held until the next slot boundary.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Strobes from the slot sequencer to the datapath.
  typedef struct packed {
    logic sample;   // copy inputs into the shadow registers
    logic blank;    // force all segments off this cycle
    logic select;   // drive the current position's common
  } scanStrobe_t;

  localparam logic [7:0] SEG_OFF = 8'h00;

  function automatic logic [7:0] digitPattern(input logic [3:0] nib);
    logic [7:0] pat;
    case (nib)
      4'd0: pat = 8'h3F;
      4'd1: pat = 8'h06;
      4'd2: pat = 8'h5B;
      4'd3: pat = 8'h4F;
      4'd4: pat = 8'h66;
      4'd5: pat = 8'h6D;
      4'd6: pat = 8'h7D;
      4'd7: pat = 8'h07;
      4'd8: pat = 8'h7F;
      4'd9: pat = 8'h6F;
      default: pat = SEG_OFF;
    endcase
    return pat;
  endfunction

  function automatic logic [7:0] unitPattern(input logic [1:0] code);
    logic [7:0] pat;
    case (code)
      2'd0: pat = 8'h01;   // segment a
      2'd1: pat = 8'h40;   // segment g
      2'd2: pat = 8'h08;   // segment d
      default: pat = SEG_OFF;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 5,
  parameter int SLOT_CYCLES  = 100000,
  parameter int BLANK_CYCLES = 4,
  localparam int NUM_POS     = NUM_DIGITS + 1,
  localparam int SEL_W       = $clog2(NUM_DIGITS + 2),
  localparam int CNT_W       = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SEL_W-1:0] pos,
  output scanStrobe_t      strobe
);

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYCLES);
  localparam logic [SEL_W-1:0] LAST_POS  = SEL_W'(NUM_POS - 1);

  logic [CNT_W-1:0] slotCnt;
  logic             slotEnd;

  assign slotEnd = (slotCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      pos     <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      pos     <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.sample = (slotCnt == '0);
    strobe.blank  = (slotCnt == '0);
    strobe.select = (slotCnt > BLANK_END);
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 5,
  parameter int DP_W       = 3,
  localparam int VAL_W     = 4 * NUM_DIGITS,
  localparam int SEL_W     = $clog2(NUM_DIGITS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] bcdValue,
  input  logic [DP_W-1:0]  dpCode,
  input  logic [1:0]       unitCode,
  input  logic [SEL_W-1:0] pos,
  input  scanStrobe_t      strobe,
  output logic [7:0]       segOut,
  output logic [SEL_W-1:0] comSel
);

  localparam logic [SEL_W-1:0] IDLE_SEL = {SEL_W{1'b1}};
  localparam logic [SEL_W-1:0] UNIT_POS = SEL_W'(NUM_DIGITS);

  logic [VAL_W-1:0] valShadow;
  logic [DP_W-1:0]  dpShadow;
  logic [1:0]       unitShadow;

  logic [3:0] digitNib [NUM_DIGITS];
  logic [3:0] curNib;
  logic       dpHit;
  logic [7:0] nextSeg;

  // Position p reads the nibble at bit offset (NUM_DIGITS-1-p)*4.
  for (genvar p = 0; p < NUM_DIGITS; p++) begin : g_nib
    assign digitNib[p] = valShadow[(NUM_DIGITS-1-p)*4 +: 4];
  end

  always_comb begin
    curNib = 4'hF;
    dpHit  = 1'b0;
    for (int p = 0; p < NUM_DIGITS; p++) begin
      if (pos == SEL_W'(p)) begin
        curNib = digitNib[p];
        dpHit  = (int'(dpShadow) == NUM_DIGITS - 1 - p);
      end
    end
  end

  always_comb begin
    if (pos == UNIT_POS) begin
      nextSeg = unitPattern(unitShadow);
    end else begin
      nextSeg    = digitPattern(curNib);
      nextSeg[7] = dpHit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valShadow  <= '0;
      dpShadow   <= '1;
      unitShadow <= '0;
      segOut     <= SEG_OFF;
      comSel     <= IDLE_SEL;
    end else begin
      if (strobe.sample) begin
        valShadow  <= bcdValue;
        dpShadow   <= dpCode;
        unitShadow <= unitCode;
      end
      segOut <= strobe.blank  ? SEG_OFF : nextSeg;
      comSel <= strobe.select ? pos     : IDLE_SEL;
    end
  end

endmodule

// File: rtl/sevenseg_scanner.sv
module sevenseg_scanner
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 5,
  parameter int DP_W         = 3,
  parameter int SLOT_CYCLES  = 100000,
  parameter int BLANK_CYCLES = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [4*NUM_DIGITS-1:0]            bcdValue,
  input  logic [DP_W-1:0]                    dpCode,
  input  logic [1:0]                         unitCode,
  output logic [7:0]                         segOut,
  output logic [$clog2(NUM_DIGITS+2)-1:0]    comSel
);

  localparam int SEL_W = $clog2(NUM_DIGITS + 2);

  logic [SEL_W-1:0] pos;
  scanStrobe_t      strobe;

  scan_ctrl #(
    .NUM_DIGITS  (NUM_DIGITS),
    .SLOT_CYCLES (SLOT_CYCLES),
    .BLANK_CYCLES(BLANK_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .pos   (pos),
    .strobe(strobe)
  );

  scan_datapath #(
    .NUM_DIGITS(NUM_DIGITS),
    .DP_W      (DP_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .bcdValue(bcdValue),
    .dpCode  (dpCode),
    .unitCode(unitCode),
    .pos     (pos),
    .strobe  (strobe),
    .segOut  (segOut),
    .comSel  (comSel)
  );

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int NUM_DIGITS   = 5,
  parameter int SLOT_CYCLES  = 100000,
  parameter int BLANK_CYCLES = 4,
  localparam int SEL_W       = $clog2(NUM_DIGITS + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       segOut,
  input logic [SEL_W-1:0] comSel
);

  localparam logic [SEL_W-1:0] IDLE_SEL = {SEL_W{1'b1}};
  localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(NUM_DIGITS);
  localparam int SEL_LEN = SLOT_CYCLES - 1 - BLANK_CYCLES;

  logic [SEL_W-1:0] lastPos;
  logic             havePos;
  logic             rstD;
  int unsigned      selCnt;

  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rst) begin
      havePos <= 1'b0;
      lastPos <= '0;
      selCnt  <= 0;
    end else begin
      if (comSel != IDLE_SEL) begin
        havePos <= 1'b1;
        lastPos <= comSel;
        selCnt  <= selCnt + 1;
      end else begin
        selCnt  <= 0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstD) begin
      AST_RESET_STATE: assert (segOut == 8'h00 && comSel == IDLE_SEL); // R9
    end
  end

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    comSel == IDLE_SEL || comSel <= LAST_POS); // R1

  AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (comSel != IDLE_SEL && $past(comSel) == IDLE_SEL && havePos)
    |-> comSel == ((lastPos == LAST_POS) ? '0 : lastPos + 1'b1)); // R1

  AST_FIRST_POS: assert property (@(posedge clk) disable iff (rst)
    (comSel != IDLE_SEL && !havePos) |-> comSel == '0); // R9

  AST_SELECT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (comSel != IDLE_SEL) |-> selCnt < SEL_LEN); // R2

  AST_SEG_CHANGE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !$stable(segOut) |-> comSel == IDLE_SEL); // R7

  AST_UNIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (comSel == LAST_POS) |-> $onehot0(segOut)); // R6

  AST_NO_DP_ON_UNIT: assert property (@(posedge clk) disable iff (rst)
    (comSel == LAST_POS) |-> !segOut[7]); // R5

endmodule

bind sevenseg_scanner scan_checker #(
  .NUM_DIGITS  (NUM_DIGITS),
  .SLOT_CYCLES (SLOT_CYCLES),
  .BLANK_CYCLES(BLANK_CYCLES)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .segOut(segOut),
  .comSel(comSel)
);

// File: tb/tb_sevenseg_scanner.sv
module tb_sevenseg_scanner;

  localparam int ND    = 5;
  localparam int SLOT  = 16;
  localparam int BLANK = 3;
  localparam int SELW  = 3;
  localparam logic [SELW-1:0] IDLE = 3'd7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [19:0]     bcdValue = '0;
  logic [2:0]      dpCode = 3'd7;
  logic [1:0]      unitCode = 2'd0;
  logic [7:0]      segOut;
  logic [SELW-1:0] comSel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sevenseg_scanner #(
    .NUM_DIGITS(ND), .DP_W(3), .SLOT_CYCLES(SLOT), .BLANK_CYCLES(BLANK)
  ) dut (
    .clk(clk), .rst(rst), .bcdValue(bcdValue), .dpCode(dpCode),
    .unitCode(unitCode), .segOut(segOut), .comSel(comSel)
  );

  function automatic logic [7:0] expSeg(logic [19:0] v, logic [2:0] dp,
                                        logic [1:0] u, int p);
    logic [7:0] s;
    logic [3:0] n;
    if (p == ND) begin
      case (u)
        2'd0: s = 8'h01;
        2'd1: s = 8'h40;
        2'd2: s = 8'h08;
        default: s = 8'h00;
      endcase
      return s;
    end
    n = v[(ND-1-p)*4 +: 4];
    case (n)
      4'd0: s = 8'h3F; 4'd1: s = 8'h06; 4'd2: s = 8'h5B; 4'd3: s = 8'h4F;
      4'd4: s = 8'h66; 4'd5: s = 8'h6D; 4'd6: s = 8'h7D; 4'd7: s = 8'h07;
      4'd8: s = 8'h7F; 4'd9: s = 8'h6F;
      default: s = 8'h00;
    endcase
    if (int'(dp) == ND - 1 - p) s[7] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitSel(input int p);
    int n = 0;
    @(negedge clk);
    while (int'(comSel) != p && n < 8 * SLOT * 6) begin
      @(negedge clk);
      n++;
    end
    if (n >= 8 * SLOT * 6) chk("R1 wait for position", int'(comSel), p);
  endtask

  task automatic driveInputs(input logic [19:0] v, input logic [2:0] dp,
                             input logic [1:0] u);
    bcdValue = v;
    dpCode   = dp;
    unitCode = u;
  endtask

  // Load a value during slot 5, then check one full rotation.
  task automatic showAndCheck(input logic [19:0] v, input logic [2:0] dp,
                              input logic [1:0] u, input string req);
    waitSel(ND);
    driveInputs(v, dp, u);
    for (int p = 0; p <= ND; p++) begin
      waitSel(p);
      chk(req, int'(segOut), int'(expSeg(v, dp, u, p)));
    end
  endtask

  task automatic t_reset;
    int idleCnt = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset segOut", int'(segOut), 0);
    chk("R9 reset comSel", int'(comSel), int'(IDLE));
    driveInputs(20'h00000, 3'd7, 2'd0);
    rst = 1'b0;
    @(negedge clk);
    while (comSel == IDLE && idleCnt < SLOT * 2) begin
      idleCnt++;
      @(negedge clk);
    end
    chk("R9 idle cycles before first select", idleCnt, BLANK + 1);
    chk("R9 first position after reset", int'(comSel), 0);
    chk("R9 first pattern", int'(segOut), int'(expSeg(20'h0, 3'd7, 2'd0, 0)));
  endtask

  task automatic t_timing;
    int n = 0;
    logic [19:0] v = 20'h24680;
    showAndCheck(v, 3'd7, 2'd1, "R3 timing setup");
    waitSel(1);
    do @(negedge clk); while (comSel == 3'd1);
    chk("R7 blank cycle segOut", int'(segOut), 0);
    chk("R7 blank cycle comSel", int'(comSel), int'(IDLE));
    for (int i = 0; i < BLANK; i++) begin
      @(negedge clk);
      chk("R7 data before select comSel", int'(comSel), int'(IDLE));
      chk("R7 data before select segOut", int'(segOut),
          int'(expSeg(v, 3'd7, 2'd1, 2)));
    end
    @(negedge clk);
    while (comSel == 3'd2) begin
      n++;
      @(negedge clk);
    end
    chk("R2 selected window length", n, SLOT - 1 - BLANK);
    chk("R2 slot length", 1 + BLANK + n, SLOT);
  endtask

  task automatic t_order;
    int prev;
    waitSel(ND);
    prev = ND;
    for (int k = 0; k < 13; k++) begin
      while (comSel != IDLE) @(negedge clk);
      while (comSel == IDLE) @(negedge clk);
      chk("R1 scan order", int'(comSel), (prev + 1) % (ND + 1));
      prev = int'(comSel);
    end
  endtask

  task automatic t_digits;
    showAndCheck(20'h01234, 3'd7, 2'd0, "R3 R4 digits 0-4");
    showAndCheck(20'h56789, 3'd7, 2'd0, "R3 R4 digits 5-9");
    showAndCheck(20'hABCDE, 3'd7, 2'd0, "R4 nibbles 10-14 blank");
    showAndCheck(20'h9F0F7, 3'd7, 2'd0, "R4 nibble 15 blank mixed");
    showAndCheck(20'h10000, 3'd7, 2'd0, "R3 position 0 most significant");
  endtask

  task automatic t_dp;
    for (int d = 0; d < 8; d++)
      showAndCheck(20'h88888, 3'(d), 2'd2, "R5 decimal point code");
  endtask

  task automatic t_unit;
    for (int u = 0; u < 4; u++)
      showAndCheck(20'h31415, 3'd2, 2'(u), "R6 unit marker");
  endtask

  task automatic t_sample;
    logic [19:0] v1 = 20'h12345;
    logic [19:0] v2 = 20'h67890;
    showAndCheck(v1, 3'd4, 2'd0, "R8 first value");
    waitSel(2);
    chk("R8 old value at slot 2", int'(segOut), int'(expSeg(v1, 3'd4, 2'd0, 2)));
    driveInputs(v2, 3'd1, 2'd2);
    while (comSel == 3'd2) begin
      chk("R8 mid-slot change ignored", int'(segOut),
          int'(expSeg(v1, 3'd4, 2'd0, 2)));
      @(negedge clk);
    end
    waitSel(3);
    chk("R8 new value at next slot", int'(segOut), int'(expSeg(v2, 3'd1, 2'd2, 3)));
    waitSel(ND);
    chk("R8 new unit at slot 5", int'(segOut), int'(expSeg(v2, 3'd1, 2'd2, ND)));
  endtask

  initial begin
    t_reset();
    t_timing();
    t_order();
    t_digits();
    t_dp();
    t_unit();
    t_sample();
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule